// File: doc/BRIEF.md
# G.711 Companding Sample Converter

This block converts audio samples between the 8-bit companded telephony codes (A-law or µ-law) and 16-bit two's-complement linear samples that are left-aligned in their word. It has two independent streaming channels. The expand channel takes an 8-bit code and returns the matching linear sample. The compress channel takes a 16-bit linear sample and returns the matching 8-bit code. A single control pin, `law_mu`, picks the companding law for both channels.

Each channel is a valid/ready stream on both sides, with a one-entry result register in between. A sample that is accepted on a clock edge produces its result at that same edge. The result is offered with `*_out_valid` high from the next cycle and stays offered until the consumer takes it. Back-pressure rules: an input is accepted only when `*_in_valid` and `*_in_ready` are both high at a rising edge. `*_in_ready` is high when the result register is empty, or when its current result is being taken in that same cycle. While `*_out_valid` is high and `*_out_ready` is low, the offered result and the valid flag hold still.

The law is captured together with each accepted sample. Changing `law_mu` later never alters a result that is already held. The low bits that the law cannot represent are dropped on compression and read as zero on expansion.

Top module: `g711_codec`

## Requirements
- R1: Expanding in A-law mode works on the code after it is XORed with 0x55. Bit 7 is the sign (1 = positive), bits 6:4 are the segment and bits 3:0 the mantissa. The result is the standard G.711 A-law value scaled by 8 into 16 bits: 0xD5→0x0008, 0x55→0xFFF8, 0xAA→0x7E00, 0x2A→0x8200, 0xC5→0x0108.
- R2: Expanding in µ-law mode works on the inverted code. Bit 7 of the inverted code is the sign (1 = negative), bits 6:4 the segment and bits 3:0 the mantissa, with the bias of 33 (132 at 16-bit scale) removed: 0xFF→0x0000, 0x7F→0x0000, 0x80→0x7D7C, 0x00→0x8284, 0xEF→0x0084.
- R3: Compressing in A-law mode uses linear bits 15:3 only and ignores bits 2:0: 0x0000→0xD5, 0x0007→0xD5, 0xFFF8→0x55, 0x7FFF→0xAA, 0x8000→0x2A, 0x0108→0xC5.
- R4: Compressing in µ-law mode uses linear bits 15:2 only and ignores bits 1:0. It adds 33 to the magnitude and clips at the top code: 0x0000→0xFF, 0x0003→0xFF, 0x7FFF→0x80, 0x8000→0x00, 0xFFFC→0x7E, 0x0084→0xEF.
- R5: An expanded sample has bits 2:0 zero in A-law mode and bits 1:0 zero in µ-law mode.
- R6: A sample accepted at a rising edge gives `*_out_valid` high with its result from that edge on.
- R7: While `*_out_valid` is high and `*_out_ready` is low, the result and valid flag hold, and `*_in_ready` is low. A result taken in the same cycle as a new input lets the new result follow with no gap.
- R8: The law in force is the value of `law_mu` at the edge of acceptance. A later change leaves a held result unchanged.
- R9: After reset, both valid flags are low and both result registers read zero.
- R10: The two channels are independent. Activity on one channel never raises the other channel's valid flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| law_mu | input | 1 | Law select: 0 = A-law, 1 = µ-law |
| exp_in_valid | input | 1 | Expand channel: code offered |
| exp_in_ready | output | 1 | Expand channel: code can be accepted |
| exp_in_code | input | 8 | Expand channel: companded code |
| exp_out_valid | output | 1 | Expand channel: linear result held |
| exp_out_ready | input | 1 | Expand channel: consumer takes result |
| exp_out_lin | output | 16 | Expand channel: left-aligned linear sample |
| cmp_in_valid | input | 1 | Compress channel: sample offered |
| cmp_in_ready | output | 1 | Compress channel: sample can be accepted |
| cmp_in_lin | input | 16 | Compress channel: left-aligned linear sample |
| cmp_out_valid | output | 1 | Compress channel: code held |
| cmp_out_ready | input | 1 | Compress channel: consumer takes code |
| cmp_out_code | output | 8 | Compress channel: companded code |

## Verification
Both conversions are driven with the sign extremes: full-scale positive and negative, the smallest magnitudes around zero, and a value on a segment boundary. These show sign handling, the top-segment clip and segment selection apart for each law. Compression inputs that differ only in the ignored low bits must give the same code, which shows that the law-specific truncation is right. Directed sequences then stall the consumer, switch the law while a result is held, and feed one channel while the other is idle. These separate correct holding and law capture from a design that recomputes its result from live inputs.

// File: rtl/g711_pkg.sv
package g711_pkg;
  localparam int CODE_W = 8;
  localparam int LIN_W  = 16;
  localparam int SEG_W  = 3;
  localparam int MAN_W  = 4;
  // A-law keeps 13 significant linear bits, mu-law keeps 14
  localparam int A_SIG  = 13;
  localparam int MU_SIG = 14;
  localparam int A_DROP  = LIN_W - A_SIG;
  localparam int MU_DROP = LIN_W - MU_SIG;
  localparam logic [CODE_W-1:0] A_EVEN_FLIP = 8'h55;
  localparam int MU_BIAS = 33;
  localparam int MU_CLIP = 8159;

  typedef enum logic {LAW_A = 1'b0, LAW_MU = 1'b1} law_e;
endpackage

// File: rtl/g711_expand.sv
module g711_expand
  import g711_pkg::*;
(
  input  logic              law_mu,
  input  logic [CODE_W-1:0] code,
  output logic [LIN_W-1:0]  lin
);
  logic [CODE_W-1:0] ca, cu;
  logic [LIN_W-1:0]  base_a, mag_a, mag_u;
  logic [SEG_W-1:0]  seg_a, seg_u;

  always_comb begin
    // A-law: restore even bits, then segment/mantissa to magnitude
    ca     = code ^ A_EVEN_FLIP;
    seg_a  = ca[6:4];
    base_a = LIN_W'({ca[3:0], 4'b0000}) + ((seg_a == '0) ? LIN_W'(8) : LIN_W'(16'h108));
    mag_a  = (seg_a <= 3'd1) ? base_a : (base_a << (seg_a - 3'd1));
    // mu-law: invert, build biased magnitude, remove bias
    cu     = ~code;
    seg_u  = cu[6:4];
    mag_u  = (LIN_W'({cu[3:0], 3'b000}) + LIN_W'(4 * MU_BIAS)) << seg_u;
    if (law_mu == LAW_MU)
      lin = cu[7] ? (LIN_W'(4 * MU_BIAS) - mag_u) : (mag_u - LIN_W'(4 * MU_BIAS));
    else
      lin = ca[7] ? mag_a : (LIN_W'(0) - mag_a);
  end
endmodule

// File: rtl/g711_compress.sv
module g711_compress
  import g711_pkg::*;
(
  input  logic              law_mu,
  input  logic [LIN_W-1:0]  lin,
  output logic [CODE_W-1:0] code
);
  // A-law path
  logic [A_SIG-1:0]  pa;
  logic [A_SIG-2:0]  mag_a;
  logic [SEG_W-1:0]  seg_a;
  logic [MAN_W-1:0]  man_a;
  logic [CODE_W-1:0] code_a;
  // mu-law path
  logic [MU_SIG-1:0] pu;
  logic              neg_u;
  logic [MU_SIG:0]   mag_u;
  logic [MU_SIG-1:0] clip_u;
  logic [MU_SIG-1:0] bias_u;
  logic [SEG_W:0]    seg_u;
  logic [MAN_W-1:0]  man_u;
  logic [CODE_W-1:0] code_u;

  always_comb begin
    pa    = lin[LIN_W-1:A_DROP];
    mag_a = pa[A_SIG-1] ? ~pa[A_SIG-2:0] : pa[A_SIG-2:0];
    seg_a = '0;
    for (int i = 0; i < 7; i++)
      if (mag_a[5+i]) seg_a = SEG_W'(i + 1);
    if (seg_a < 3'd2) man_a = mag_a[4:1];
    else              man_a = MAN_W'(mag_a >> seg_a);
    code_a = {~pa[A_SIG-1], seg_a, man_a} ^ A_EVEN_FLIP;
  end

  always_comb begin
    pu     = lin[LIN_W-1:MU_DROP];
    neg_u  = pu[MU_SIG-1];
    mag_u  = neg_u ? ((MU_SIG+1)'(0) - {pu[MU_SIG-1], pu}) : {1'b0, pu};
    clip_u = (mag_u > (MU_SIG+1)'(MU_CLIP)) ? MU_SIG'(MU_CLIP) : mag_u[MU_SIG-1:0];
    bias_u = clip_u + MU_SIG'(MU_BIAS);
    seg_u  = '0;
    for (int i = 0; i < 8; i++)
      if (bias_u[6+i]) seg_u = (SEG_W+1)'(i + 1);
    man_u  = MAN_W'(bias_u >> (seg_u + 4'd1));
    if (seg_u[SEG_W])
      code_u = 8'h7F ^ (neg_u ? 8'h7F : 8'hFF);
    else
      code_u = {1'b0, seg_u[SEG_W-1:0], man_u} ^ (neg_u ? 8'h7F : 8'hFF);
  end

  assign code = (law_mu == LAW_MU) ? code_u : code_a;
endmodule

// File: rtl/g711_hold.sv
module g711_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/g711_codec.sv
module g711_codec
  import g711_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              law_mu,
  input  logic              exp_in_valid,
  output logic              exp_in_ready,
  input  logic [CODE_W-1:0] exp_in_code,
  output logic              exp_out_valid,
  input  logic              exp_out_ready,
  output logic [LIN_W-1:0]  exp_out_lin,
  input  logic              cmp_in_valid,
  output logic              cmp_in_ready,
  input  logic [LIN_W-1:0]  cmp_in_lin,
  output logic              cmp_out_valid,
  input  logic              cmp_out_ready,
  output logic [CODE_W-1:0] cmp_out_code
);
  logic [LIN_W-1:0]  exp_lin_c;
  logic [CODE_W-1:0] cmp_code_c;

  g711_expand u_expand (.law_mu(law_mu), .code(exp_in_code), .lin(exp_lin_c));

  g711_compress u_compress (.law_mu(law_mu), .lin(cmp_in_lin), .code(cmp_code_c));

  g711_hold #(.W(LIN_W)) u_exp_hold (
    .clk(clk), .rst_n(rst_n),
    .in_valid(exp_in_valid), .in_ready(exp_in_ready), .in_data(exp_lin_c),
    .out_valid(exp_out_valid), .out_ready(exp_out_ready), .out_data(exp_out_lin)
  );

  g711_hold #(.W(CODE_W)) u_cmp_hold (
    .clk(clk), .rst_n(rst_n),
    .in_valid(cmp_in_valid), .in_ready(cmp_in_ready), .in_data(cmp_code_c),
    .out_valid(cmp_out_valid), .out_ready(cmp_out_ready), .out_data(cmp_out_code)
  );
endmodule

// File: rtl/g711_codec_chk.sv
module g711_codec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        law_mu,
  input logic        exp_in_valid,
  input logic        exp_in_ready,
  input logic        exp_out_valid,
  input logic        exp_out_ready,
  input logic [15:0] exp_out_lin,
  input logic        cmp_in_valid,
  input logic        cmp_in_ready,
  input logic        cmp_out_valid,
  input logic        cmp_out_ready,
  input logic [7:0]  cmp_out_code
);
  a_r7_exp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    exp_out_valid && !exp_out_ready |=> exp_out_valid && $stable(exp_out_lin));
  a_r7_cmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_out_valid && !cmp_out_ready |=> cmp_out_valid && $stable(cmp_out_code));
  a_r6_exp_latency: assert property (@(posedge clk) disable iff (!rst_n)
    exp_in_valid && exp_in_ready |=> exp_out_valid);
  a_r6_cmp_latency: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_in_valid && cmp_in_ready |=> cmp_out_valid);
  a_r5_alaw_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    exp_in_valid && exp_in_ready && !law_mu |=> exp_out_lin[2:0] == 3'b000);
  a_r5_mulaw_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    exp_in_valid && exp_in_ready && law_mu |=> exp_out_lin[1:0] == 2'b00);
  a_r10_exp_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !exp_out_valid && !(exp_in_valid && exp_in_ready) |=> !exp_out_valid);
  a_r10_cmp_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_out_valid && !(cmp_in_valid && cmp_in_ready) |=> !cmp_out_valid);
endmodule

bind g711_codec g711_codec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .law_mu(law_mu),
  .exp_in_valid(exp_in_valid), .exp_in_ready(exp_in_ready),
  .exp_out_valid(exp_out_valid), .exp_out_ready(exp_out_ready), .exp_out_lin(exp_out_lin),
  .cmp_in_valid(cmp_in_valid), .cmp_in_ready(cmp_in_ready),
  .cmp_out_valid(cmp_out_valid), .cmp_out_ready(cmp_out_ready), .cmp_out_code(cmp_out_code)
);

// File: tb/test_g711_codec.sv
`timescale 1ns/1ps
module test_g711_codec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        law_mu = 1'b0;
  logic        exp_in_valid = 1'b0, exp_in_ready, exp_out_valid, exp_out_ready = 1'b0;
  logic [7:0]  exp_in_code = '0;
  logic [15:0] exp_out_lin;
  logic        cmp_in_valid = 1'b0, cmp_in_ready, cmp_out_valid, cmp_out_ready = 1'b0;
  logic [15:0] cmp_in_lin = '0;
  logic [7:0]  cmp_out_code;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  g711_codec i_g711_codec (.*);

  // {compress, law, input, expected}
  localparam int NV = 22;
  localparam logic [33:0] VEC [NV] = '{
    {1'b0, 1'b0, 16'h00D5, 16'h0008}, {1'b0, 1'b0, 16'h0055, 16'hFFF8},
    {1'b0, 1'b0, 16'h00AA, 16'h7E00}, {1'b0, 1'b0, 16'h002A, 16'h8200},
    {1'b0, 1'b0, 16'h00C5, 16'h0108},
    {1'b0, 1'b1, 16'h00FF, 16'h0000}, {1'b0, 1'b1, 16'h007F, 16'h0000},
    {1'b0, 1'b1, 16'h0080, 16'h7D7C}, {1'b0, 1'b1, 16'h0000, 16'h8284},
    {1'b0, 1'b1, 16'h00EF, 16'h0084},
    {1'b1, 1'b0, 16'h0000, 16'h00D5}, {1'b1, 1'b0, 16'h0007, 16'h00D5},
    {1'b1, 1'b0, 16'hFFF8, 16'h0055}, {1'b1, 1'b0, 16'h7FFF, 16'h00AA},
    {1'b1, 1'b0, 16'h8000, 16'h002A}, {1'b1, 1'b0, 16'h0108, 16'h00C5},
    {1'b1, 1'b1, 16'h0000, 16'h00FF}, {1'b1, 1'b1, 16'h0003, 16'h00FF},
    {1'b1, 1'b1, 16'h7FFF, 16'h0080}, {1'b1, 1'b1, 16'h8000, 16'h0000},
    {1'b1, 1'b1, 16'hFFFC, 16'h007E}, {1'b1, 1'b1, 16'h0084, 16'h00EF}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // present one item on a channel, accept at next edge, return at the negedge after
  task automatic push(input logic comp, input logic law, input logic [15:0] din);
    @(negedge clk);
    law_mu = law;
    if (comp) begin cmp_in_valid = 1'b1; cmp_in_lin = din; end
    else begin exp_in_valid = 1'b1; exp_in_code = din[7:0]; end
    @(negedge clk);
    cmp_in_valid = 1'b0;
    exp_in_valid = 1'b0;
  endtask

  task automatic pop(input logic comp);
    if (comp) cmp_out_ready = 1'b1; else exp_out_ready = 1'b1;
    @(negedge clk);
    cmp_out_ready = 1'b0;
    exp_out_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 exp valid", 16'(exp_out_valid), 16'h0);
    chk("R9 exp data", exp_out_lin, 16'h0);
    chk("R9 cmp valid", 16'(cmp_out_valid), 16'h0);
    chk("R9 cmp data", 16'(cmp_out_code), 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R1 R2 R3 R4, with R6 latency and R10 isolation
    for (int i = 0; i < NV; i++) begin
      logic comp, law;
      logic [15:0] din, dexp;
      string tag;
      {comp, law, din, dexp} = VEC[i];
      tag = comp ? (law ? "R4" : "R3") : (law ? "R2" : "R1");
      push(comp, law, din);
      if (comp) begin
        chk("R6 cmp valid", 16'(cmp_out_valid), 16'h1);
        chk(tag, 16'(cmp_out_code), dexp);
        chk("R10 exp idle", 16'(exp_out_valid), 16'h0);
      end else begin
        chk("R6 exp valid", 16'(exp_out_valid), 16'h1);
        chk(tag, exp_out_lin, dexp);
        chk("R10 cmp idle", 16'(cmp_out_valid), 16'h0);
      end
      pop(comp);
      chk("R7 consumed", 16'(comp ? cmp_out_valid : exp_out_valid), 16'h0);
    end

    // R5: low bits cleared per law
    push(1'b0, 1'b0, 16'h0012);
    chk("R5 alaw low bits", 16'(exp_out_lin[2:0]), 16'h0);
    pop(1'b0);
    push(1'b0, 1'b1, 16'h003A);
    chk("R5 mulaw low bits", 16'(exp_out_lin[1:0]), 16'h0);
    pop(1'b0);

    // R7 + R8: hold under back-pressure, law change leaves held result
    push(1'b0, 1'b0, 16'h00D5);
    chk("R7 ready low while held", 16'(exp_in_ready), 16'h0);
    law_mu = 1'b1;
    exp_in_valid = 1'b1;
    exp_in_code = 8'h80;
    repeat (3) @(negedge clk);
    chk("R8 held after law change", exp_out_lin, 16'h0008);
    chk("R7 still valid", 16'(exp_out_valid), 16'h1);
    // consume and accept in same cycle: new result follows at once
    exp_out_ready = 1'b1;
    @(negedge clk);
    exp_out_ready = 1'b0;
    exp_in_valid = 1'b0;
    chk("R7 back-to-back valid", 16'(exp_out_valid), 16'h1);
    chk("R7 back-to-back data", exp_out_lin, 16'h7D7C);
    pop(1'b0);

    // R8 on compress channel
    push(1'b1, 1'b1, 16'h0000);
    law_mu = 1'b0;
    @(negedge clk);
    chk("R8 cmp held code", 16'(cmp_out_code), 16'h00FF);
    pop(1'b1);

    // R10: both channels at once
    @(negedge clk);
    law_mu = 1'b0;
    exp_in_valid = 1'b1; exp_in_code = 8'hAA;
    cmp_in_valid = 1'b1; cmp_in_lin = 16'h8000;
    @(negedge clk);
    exp_in_valid = 1'b0; cmp_in_valid = 1'b0;
    chk("R10 exp result", exp_out_lin, 16'h7E00);
    chk("R10 cmp result", 16'(cmp_out_code), 16'h002A);
    pop(1'b0);
    chk("R10 cmp unaffected", 16'(cmp_out_valid), 16'h1);
    pop(1'b1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule